// File: doc/BRIEF.md
# Transaction Retry and Irrevocability Controller

This block decides how each hardware thread proceeds after a speculative transaction fails. Threads report transaction events to the block one at a time: the start of a transaction at a code site, a successful commit, or a failure with a cause. For every start and every failure that counts, the block returns a decision for that thread. The decision says either to try again speculatively or to run irrevocably.

A thread told to run irrevocably queues for a single global token. It runs serialized once it holds the token and frees the token by committing. Speculative threads continue alongside the token holder.

Failures from conflicts or from capacity overflow get a bounded number of speculative retries. Any other cause sends the thread straight to irrevocable mode. Each thread counts its commits and its irrevocable commits. When an irrevocable commit leaves that ratio above a threshold, the transaction's site goes into a small aging table. A site found in that table gets only one speculative attempt.

Events arrive on a valid/ready stream and decisions leave on a second valid/ready stream. There is a single decision register. An event is accepted (`ev_ready` high) only when that register is empty or is being drained in the same cycle (`dec_ready` high). While `dec_valid` is high and `dec_ready` is low, the decision holds steady and no event is taken. Commits produce no decision.

Top module: `txn_retry_ctrl`

## Requirements
- R1: An accepted begin event (`ev_kind`=0) from a thread gives a decision for that thread with `dec_irrev`=0 in the next cycle. It also clears that thread's retry count and records `ev_site` as the thread's current site.
- R2: A failure (`ev_kind`=2) with cause conflict (`ev_cause`=0) or capacity (`ev_cause`=1) from a non-holder on a site not in the table is handled by retry count. The first `cfg_retry_limit` such failures after a begin decide `dec_irrev`=0, and the next one decides `dec_irrev`=1.
- R3: A failure from a non-holder with cause jail violation (`ev_cause`=2) or the reserved cause 3 decides `dec_irrev`=1 at once.
- R4: A decision with `dec_irrev`=1 queues a token request. A free token goes to a queued thread on the clock edge after its request was queued. The search for the next owner starts just after the previous owner's index and wraps around. Only one owner exists at any time.
- R5: A failure from the current token holder is ignored. It produces no decision and the token stays with that holder.
- R6: A commit (`ev_kind`=1) produces no decision. A commit from the token holder frees the token at that edge, so `tok_busy` is low in the following cycle.
- R7: On a holder commit, the thread's commit counters are updated first. If irrevocable_commits × 100 > `cfg_ser_thresh` × total_commits, the thread's current site is entered into the problem table, or its entry is refreshed if already present.
- R8: A begin on a site present in the table still decides `dec_irrev`=0. The first failure of that transaction, whatever its cause, decides `dec_irrev`=1.
- R9: A table entry entered at edge E matches begin events accepted at edges E+1 through E+`cfg_residency`, and none after.
- R10: `ev_ready` is low whenever `dec_valid` is high and `dec_ready` is low. During such a stall, `dec_tid` and `dec_irrev` hold their values and the waiting event is not consumed.
- R11: The per-thread total and irrevocable commit counters saturate at their all-ones value rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_retry_limit | input | RCW | Speculative retries allowed for transient failures |
| cfg_ser_thresh | input | 8 | Serialization-ratio threshold in percent |
| cfg_residency | input | AGEW | Problem-table residency in cycles (values of 0 act as 1) |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event accepted this cycle when high with ev_valid |
| ev_kind | input | 2 | 0 begin, 1 commit, 2 failure, 3 ignored |
| ev_tid | input | TIDW | Reporting thread |
| ev_site | input | SITEW | Transaction site (used on begin) |
| ev_cause | input | 2 | 0 conflict, 1 capacity, 2 jail violation, 3 reserved |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_tid | output | TIDW | Thread the decision is for |
| dec_irrev | output | 1 | 1 run irrevocably, 0 retry speculatively |
| tok_busy | output | 1 | Irrevocable token is held |
| tok_owner | output | TIDW | Current token holder |

## Verification
The bench builds the block with four threads, a two-entry problem table and 4-bit commit counters. A retry limit of three and a residency of eight cycles bring full-table replacement, entry expiry and counter saturation within a few dozen events. With only four threads, a wrap-around token search with three waiting requesters is easy to set up: the owner chosen differs from what a fixed-priority grant would pick. The narrow counters let a saturation test pick a threshold at which saturated counters keep a site out of the table, while wrapped ones would have let it in.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam logic [1:0] K_BEGIN  = 2'd0;
  localparam logic [1:0] K_COMMIT = 2'd1;
  localparam logic [1:0] K_FAIL   = 2'd2;

  localparam logic [1:0] C_CONFLICT = 2'd0;
  localparam logic [1:0] C_CAPACITY = 2'd1;
  localparam logic [1:0] C_JAIL     = 2'd2;

  // Transient causes may clear on their own, so they earn speculative retries.
  function automatic logic cause_transient(input logic [1:0] c);
    return (c == C_CONFLICT) || (c == C_CAPACITY);
  endfunction
endpackage

// File: rtl/txr_thread_ctx.sv
module txr_thread_ctx #(
  parameter int SITEW = 8,
  parameter int RCW   = 4,
  parameter int CNTW  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_hit,
  input  logic [1:0]       ev_kind,
  input  logic [1:0]       ev_cause,
  input  logic [SITEW-1:0] ev_site,
  input  logic             holder,
  input  logic             pt_hit,
  input  logic [RCW-1:0]   cfg_retry_limit,
  input  logic [7:0]       cfg_ser_thresh,
  output logic             fail_irrev,
  output logic             ratio_over,
  output logic [SITEW-1:0] cur_site
);
  import txr_pkg::*;
  localparam int PW = CNTW + 8;

  logic [RCW-1:0]   retry_q;
  logic             prob_q;
  logic [SITEW-1:0] site_q;
  logic [CNTW-1:0]  tot_q, irr_q, tot_nx, irr_nx;
  logic [PW-1:0]    lhs, rhs;

  assign fail_irrev = !cause_transient(ev_cause) || prob_q || (retry_q >= cfg_retry_limit);
  assign tot_nx = (tot_q == '1) ? tot_q : tot_q + 1'b1;
  assign irr_nx = (irr_q == '1) ? irr_q : irr_q + 1'b1;
  assign lhs = PW'(irr_nx) * PW'(100);
  assign rhs = PW'(cfg_ser_thresh) * PW'(tot_nx);
  assign ratio_over = lhs > rhs;
  assign cur_site = site_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retry_q <= '0;
      prob_q  <= 1'b0;
      site_q  <= '0;
      tot_q   <= '0;
      irr_q   <= '0;
    end else if (ev_hit) begin
      if (ev_kind == K_BEGIN) begin
        retry_q <= '0;
        prob_q  <= pt_hit;
        site_q  <= ev_site;
      end else if (ev_kind == K_FAIL && !holder && !fail_irrev) begin
        retry_q <= retry_q + 1'b1;
      end else if (ev_kind == K_COMMIT) begin
        tot_q <= tot_nx;
        if (holder) irr_q <= irr_nx;
      end
    end
  end

  p_retry_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_q != $past(retry_q)) |-> (retry_q == '0 || retry_q == $past(retry_q) + 1'b1));
  p_irr_within_tot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irr_q <= tot_q);
endmodule

// File: rtl/txr_token_arb.sv
module txr_token_arb #(
  parameter int NTHR = 16,
  parameter int TIDW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_req,
  input  logic [TIDW-1:0] set_tid,
  input  logic            release_i,
  output logic            busy,
  output logic [TIDW-1:0] owner
);
  logic [NTHR-1:0] req_q, req_set, req_clr;
  logic [TIDW-1:0] last_q, pick;
  logic            found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int off = 1; off <= NTHR; off++) begin
      int idx;
      idx = (int'(last_q) + off) % NTHR;
      if (!found && req_q[idx]) begin
        found = 1'b1;
        pick  = TIDW'(idx);
      end
    end
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_req
    assign req_set[g] = set_req && (set_tid == TIDW'(g));
    assign req_clr[g] = !busy && found && (pick == TIDW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      busy   <= 1'b0;
      owner  <= '0;
      last_q <= TIDW'(NTHR - 1);
    end else begin
      req_q <= (req_q & ~req_clr) | req_set;
      if (busy) begin
        if (release_i) busy <= 1'b0;
      end else if (found) begin
        busy   <= 1'b1;
        owner  <= pick;
        last_q <= pick;
      end
    end
  end

  p_grant_from_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_q != '0));
  p_token_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !release_i |=> busy && $stable(owner));
  p_token_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && release_i |=> !busy);
endmodule

// File: rtl/txr_site_table.sv
module txr_site_table #(
  parameter int SITEW = 8,
  parameter int DEPTH = 8,
  parameter int AGEW  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SITEW-1:0] look_site,
  output logic             look_hit,
  input  logic             ins_en,
  input  logic [SITEW-1:0] ins_site,
  input  logic [AGEW-1:0]  cfg_residency
);
  localparam int PIW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] valid_q, hit_v, match_v;
  logic [SITEW-1:0] site_q [DEPTH];
  logic [AGEW-1:0]  age_q  [DEPTH];
  logic [AGEW-1:0]  load_age;
  logic [PIW-1:0]   victim_q, slot, match_idx, free_idx;
  logic             has_match, has_free;

  assign load_age = (cfg_residency == '0) ? AGEW'(1) : cfg_residency;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign hit_v[g]   = valid_q[g] && (site_q[g] == look_site);
    assign match_v[g] = valid_q[g] && (site_q[g] == ins_site);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        site_q[g]  <= '0;
        age_q[g]   <= '0;
      end else if (ins_en && slot == PIW'(g)) begin
        valid_q[g] <= 1'b1;
        site_q[g]  <= ins_site;
        age_q[g]   <= load_age;
      end else if (valid_q[g]) begin
        if (age_q[g] == AGEW'(1)) valid_q[g] <= 1'b0;
        age_q[g] <= age_q[g] - 1'b1;
      end
    end

    p_age_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q[g] |-> age_q[g] != '0);
  end

  assign look_hit = |hit_v;

  always_comb begin
    has_match = 1'b0;
    has_free  = 1'b0;
    match_idx = '0;
    free_idx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match_v[i]) begin
        has_match = 1'b1;
        match_idx = PIW'(i);
      end
      if (!valid_q[i]) begin
        has_free = 1'b1;
        free_idx = PIW'(i);
      end
    end
    slot = has_match ? match_idx : (has_free ? free_idx : victim_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) victim_q <= '0;
    else if (ins_en && !has_match && !has_free)
      victim_q <= (victim_q == PIW'(DEPTH - 1)) ? '0 : victim_q + 1'b1;
  end

  p_insert_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> (look_site != $past(ins_site)) || look_hit);
endmodule

// File: rtl/txn_retry_ctrl.sv
module txn_retry_ctrl #(
  parameter int NTHR     = 16,
  parameter int SITEW    = 8,
  parameter int RCW      = 4,
  parameter int CNTW     = 16,
  parameter int PT_DEPTH = 8,
  parameter int AGEW     = 12,
  localparam int TIDW    = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RCW-1:0]   cfg_retry_limit,
  input  logic [7:0]       cfg_ser_thresh,
  input  logic [AGEW-1:0]  cfg_residency,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [1:0]       ev_kind,
  input  logic [TIDW-1:0]  ev_tid,
  input  logic [SITEW-1:0] ev_site,
  input  logic [1:0]       ev_cause,
  output logic             dec_valid,
  input  logic             dec_ready,
  output logic [TIDW-1:0]  dec_tid,
  output logic             dec_irrev,
  output logic             tok_busy,
  output logic [TIDW-1:0]  tok_owner
);
  import txr_pkg::*;

  logic             acc, tid_ok, holder, fail_take, need_dec;
  logic             sel_irrev, sel_over, set_req, release_tok, ins_en, pt_hit;
  logic [SITEW-1:0] ins_site;
  logic             fail_irrev_v [NTHR];
  logic             ratio_v      [NTHR];
  logic [SITEW-1:0] site_v       [NTHR];

  assign ev_ready  = !dec_valid || dec_ready;
  assign acc       = ev_valid && ev_ready;
  assign tid_ok    = int'(ev_tid) < NTHR;
  assign holder    = tok_busy && (tok_owner == ev_tid);
  assign fail_take = acc && tid_ok && (ev_kind == K_FAIL) && !holder;
  assign need_dec  = (acc && tid_ok && ev_kind == K_BEGIN) || fail_take;

  always_comb begin
    sel_irrev = 1'b0;
    sel_over  = 1'b0;
    ins_site  = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (ev_tid == TIDW'(i)) begin
        sel_irrev = fail_irrev_v[i];
        sel_over  = ratio_v[i];
        ins_site  = site_v[i];
      end
    end
  end

  assign set_req     = fail_take && sel_irrev;
  assign release_tok = acc && (ev_kind == K_COMMIT) && holder;
  assign ins_en      = release_tok && sel_over;

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    txr_thread_ctx #(.SITEW(SITEW), .RCW(RCW), .CNTW(CNTW)) u_ctx (
      .clk(clk), .rst_n(rst_n),
      .ev_hit(acc && ev_tid == TIDW'(g)),
      .ev_kind(ev_kind), .ev_cause(ev_cause), .ev_site(ev_site),
      .holder(holder), .pt_hit(pt_hit),
      .cfg_retry_limit(cfg_retry_limit), .cfg_ser_thresh(cfg_ser_thresh),
      .fail_irrev(fail_irrev_v[g]), .ratio_over(ratio_v[g]), .cur_site(site_v[g])
    );
  end

  txr_token_arb #(.NTHR(NTHR), .TIDW(TIDW)) u_arb (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .set_tid(ev_tid),
    .release_i(release_tok), .busy(tok_busy), .owner(tok_owner)
  );

  txr_site_table #(.SITEW(SITEW), .DEPTH(PT_DEPTH), .AGEW(AGEW)) u_tab (
    .clk(clk), .rst_n(rst_n), .look_site(ev_site), .look_hit(pt_hit),
    .ins_en(ins_en), .ins_site(ins_site), .cfg_residency(cfg_residency)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_tid   <= '0;
      dec_irrev <= 1'b0;
    end else if (need_dec) begin
      dec_valid <= 1'b1;
      dec_tid   <= ev_tid;
      dec_irrev <= (ev_kind == K_FAIL) && sel_irrev;
    end else if (dec_ready) begin
      dec_valid <= 1'b0;
    end
  end

  p_begin_spec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && tid_ok && ev_kind == K_BEGIN |=> dec_valid && !dec_irrev);
  p_jail_irrev_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fail_take && ev_cause == C_JAIL |=> dec_valid && dec_irrev);
  p_holder_fail_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ev_kind == K_FAIL && holder |=> !dec_valid && tok_busy);
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready |=> dec_valid && $stable(dec_tid) && $stable(dec_irrev));
endmodule

// File: tb/sim_txn_retry_ctrl.sv
`timescale 1ns/1ps
module sim_txn_retry_ctrl;
  localparam int NTHR = 4, SITEW = 6, RCW = 4, CNTW = 4, PT_DEPTH = 2, AGEW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [RCW-1:0] cfg_retry_limit;
  logic [7:0] cfg_ser_thresh;
  logic [AGEW-1:0] cfg_residency;
  logic ev_valid, ev_ready, dec_valid, dec_ready, dec_irrev, tok_busy;
  logic [1:0] ev_kind, ev_cause;
  logic [1:0] ev_tid, dec_tid, tok_owner;
  logic [SITEW-1:0] ev_site;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  txn_retry_ctrl #(.NTHR(NTHR), .SITEW(SITEW), .RCW(RCW), .CNTW(CNTW),
                   .PT_DEPTH(PT_DEPTH), .AGEW(AGEW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_retry_limit(cfg_retry_limit),
    .cfg_ser_thresh(cfg_ser_thresh), .cfg_residency(cfg_residency),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind), .ev_tid(ev_tid),
    .ev_site(ev_site), .ev_cause(ev_cause), .dec_valid(dec_valid),
    .dec_ready(dec_ready), .dec_tid(dec_tid), .dec_irrev(dec_irrev),
    .tok_busy(tok_busy), .tok_owner(tok_owner)
  );

  typedef struct packed {
    logic [1:0] k; logic [1:0] t; logic [5:0] s; logic [1:0] c; logic dv; logic irr;
  } vec_t;

  // kind 0 begin, 1 commit, 2 fail; cause 0 conflict, 1 capacity, 2 jail
  localparam vec_t VEC [16] = '{
    '{2'd0, 2'd0, 6'd5, 2'd0, 1'b1, 1'b0},
    '{2'd2, 2'd0, 6'd5, 2'd0, 1'b1, 1'b0},
    '{2'd2, 2'd0, 6'd5, 2'd1, 1'b1, 1'b0},
    '{2'd2, 2'd0, 6'd5, 2'd0, 1'b1, 1'b0},
    '{2'd2, 2'd0, 6'd5, 2'd0, 1'b1, 1'b1},
    '{2'd0, 2'd1, 6'd7, 2'd0, 1'b1, 1'b0},
    '{2'd2, 2'd1, 6'd7, 2'd2, 1'b1, 1'b1},
    '{2'd2, 2'd0, 6'd5, 2'd0, 1'b0, 1'b0},
    '{2'd1, 2'd0, 6'd5, 2'd0, 1'b0, 1'b0},
    '{2'd0, 2'd2, 6'd5, 2'd0, 1'b1, 1'b0},
    '{2'd2, 2'd2, 6'd5, 2'd0, 1'b1, 1'b1},
    '{2'd1, 2'd1, 6'd7, 2'd0, 1'b0, 1'b0},
    '{2'd0, 2'd3, 6'd9, 2'd0, 1'b1, 1'b0},
    '{2'd2, 2'd3, 6'd9, 2'd0, 1'b1, 1'b0},
    '{2'd1, 2'd3, 6'd9, 2'd0, 1'b0, 1'b0},
    '{2'd1, 2'd2, 6'd5, 2'd0, 1'b0, 1'b0}
  };
  string vtag [16] = '{"R1", "R2", "R2", "R2", "R2", "R1", "R3", "R5",
                       "R6", "R8", "R8", "R6", "R1", "R2", "R6", "R7"};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [1:0] t,
                      input logic [5:0] s, input logic [1:0] c);
    ev_kind = k; ev_tid = t; ev_site = s; ev_cause = c; ev_valid = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dec_is(input string req, input int tid, input int irr);
    chk(req, int'(dec_valid), 1);
    chk(req, int'(dec_tid), tid);
    chk(req, int'(dec_irrev), irr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ev_valid = 1'b0; dec_ready = 1'b1;
    ev_kind = '0; ev_tid = '0; ev_site = '0; ev_cause = '0;
    cfg_retry_limit = 4'd3; cfg_ser_thresh = 8'd50; cfg_residency = 8'd200;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R10 reset dec_valid", int'(dec_valid), 0);
    chk("R6 reset tok_busy", int'(tok_busy), 0);
    chk("R10 reset ev_ready", int'(ev_ready), 1);

    for (int i = 0; i < 16; i++) begin
      send(VEC[i].k, VEC[i].t, VEC[i].s, VEC[i].c);
      chk(vtag[i], int'(dec_valid), int'(VEC[i].dv));
      if (VEC[i].dv) begin
        chk(vtag[i], int'(dec_tid), int'(VEC[i].t));
        chk(vtag[i], int'(dec_irrev), int'(VEC[i].irr));
      end
      if (i == 7) begin
        chk("R5 holder kept", int'(tok_busy), 1);
        chk("R5 holder kept", int'(tok_owner), 0);
      end
    end

    // R4 round robin: last owner 2, then owner 1; waiting 0 and 3 -> 3 first
    send(2'd0, 2'd1, 6'd11, 2'd0); dec_is("R1", 1, 0);
    send(2'd2, 2'd1, 6'd11, 2'd2); dec_is("R3", 1, 1);
    idle(1);
    chk("R4 grant", int'(tok_busy), 1);
    chk("R4 grant owner", int'(tok_owner), 1);
    send(2'd0, 2'd0, 6'd12, 2'd0);
    send(2'd2, 2'd0, 6'd12, 2'd2); dec_is("R3", 0, 1);
    send(2'd0, 2'd3, 6'd13, 2'd0);
    send(2'd2, 2'd3, 6'd13, 2'd2); dec_is("R3", 3, 1);
    chk("R4 single owner", int'(tok_owner), 1);
    send(2'd1, 2'd1, 6'd0, 2'd0);
    chk("R6 release", int'(tok_busy), 0);
    chk("R6 commit no decision", int'(dec_valid), 0);
    idle(1);
    chk("R4 rr owner", int'(tok_owner), 3);
    send(2'd1, 2'd3, 6'd0, 2'd0);
    idle(1);
    chk("R4 rr next", int'(tok_owner), 0);
    send(2'd1, 2'd0, 6'd0, 2'd0);
    chk("R6 release", int'(tok_busy), 0);

    // R9 expiry with residency 8
    cfg_residency = 8'd8;
    send(2'd0, 2'd2, 6'd20, 2'd0);
    send(2'd2, 2'd2, 6'd20, 2'd2);
    idle(1);
    chk("R4 owner", int'(tok_owner), 2);
    send(2'd1, 2'd2, 6'd0, 2'd0);
    idle(7);
    send(2'd0, 2'd0, 6'd20, 2'd0); dec_is("R8", 0, 0);
    send(2'd2, 2'd0, 6'd0, 2'd0);  dec_is("R9 last live cycle", 0, 1);
    idle(1);
    send(2'd1, 2'd0, 6'd0, 2'd0);
    idle(8);
    send(2'd0, 2'd3, 6'd20, 2'd0);
    send(2'd2, 2'd3, 6'd0, 2'd0);  dec_is("R9 expired", 3, 0);
    send(2'd1, 2'd3, 6'd0, 2'd0);

    // R11 saturation: thread 3 at tot 3 irr 1
    for (int j = 0; j < 15; j++) send(2'd1, 2'd3, 6'd0, 2'd0);
    cfg_ser_thresh = 8'd14;
    send(2'd0, 2'd3, 6'd30, 2'd0);
    send(2'd2, 2'd3, 6'd30, 2'd2);
    idle(1);
    chk("R4 owner", int'(tok_owner), 3);
    send(2'd1, 2'd3, 6'd0, 2'd0);
    send(2'd0, 2'd1, 6'd30, 2'd0);
    send(2'd2, 2'd1, 6'd0, 2'd0);  dec_is("R11 saturated ratio", 1, 0);

    // R10 back-pressure
    dec_ready = 1'b0;
    send(2'd0, 2'd1, 6'd40, 2'd0);
    dec_is("R10 stalled", 1, 0);
    chk("R10 ready low", int'(ev_ready), 0);
    ev_kind = 2'd2; ev_tid = 2'd1; ev_cause = 2'd2; ev_valid = 1'b1;
    idle(2);
    dec_is("R10 held", 1, 0);
    dec_ready = 1'b1;
    idle(1);
    ev_valid = 1'b0;
    dec_is("R10 taken after drain", 1, 1);
    idle(1);
    chk("R10 drained", int'(dec_valid), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule